// File: doc/BRIEF.md
# Dual-Core Boot Hold Controller

This block is a small memory-mapped control register bank for holding processor cores in a wait state after system reset, and for letting them go under software control. Each core has a hold level, a one-cycle release pulse that requests power-on and reset of that core, and a programmable secure vector table base. The core samples that base only when it next comes out of reset.

Software uses a plain 32-bit register bus. It clears a core's bit in the wait register, and that core receives a release pulse. Setting the bit again never halts a running core. Four read-only identification bytes sit at the top of the word space. The parameter `NUM_CORES` picks a single-core or dual-core build. In the single-core build the second core's vector base register does not exist.

The bus has no handshake. A read or write is accepted in the cycle it is presented. Read data and the error flag appear in the following cycle.

Top module: `boot_hold_ctrl`

## Requirements
- R1: After reset, both vector bases read 0x10000000. The wait register reads 2 when NUM_CORES=2 and 0 when NUM_CORES=1. `core_hold` equals the low NUM_CORES bits of that value, and `core_release`, `bus_rdata` and `bus_err` are 0.
- R2: The wait register at byte offset 0x008 stores all 32 written bits and returns them on a read, whether or not a release happened.
- R3: A write that changes bit i (i=0 for core 0, i=1 for core 1) of the wait register from 1 to 0 makes `core_release[i]` high for exactly the one cycle after the write. No other write produces a pulse.
- R4: `core_hold[i]` falls together with the release pulse of core i and never rises again until reset. Writing 1 to a wait bit does not reassert a hold.
- R5: The vector base registers are at byte offset 0x000 for core 0 and 0x004 for core 1. A write replaces all 32 bits, is readable, and is presented on `core_vec_base` (core c at bits c*32+31..c*32) from the next cycle.
- R6: Byte offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1, zero-extended. Writes there change nothing and raise no error.
- R7: A read or write to any other offset, or to an address with nonzero low two bits, gives `bus_rdata`=0 and `bus_err`=1 in the following cycle only. Such a write changes no state.
- R8: With NUM_CORES=1, offset 0x004 is treated as unmapped, as in R7.
- R9: `bus_rdata` holds the addressed value in the cycle after a read and is 0 in every cycle not preceded by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| bus_err | output | 1 | Invalid offset flag, one cycle after the access |
| core_hold | output | NUM_CORES | Per-core wait level |
| core_release | output | NUM_CORES | Per-core one-cycle power-on-and-reset request |
| core_vec_base | output | NUM_CORES*DATA_W | Per-core secure vector table base |

## Verification
A wrong stored wait value shows on the next read of offset 0x008. It also shows in the release pulses of later writes, which would appear or go missing in the cycle after those writes. A hold bit in the wrong state is visible on `core_hold` right away and stays wrong until reset, because nothing but a release can change it. A bad vector base shows on `core_vec_base` one cycle after the write that caused it. A decode fault shows as a wrong `bus_err` or `bus_rdata` one cycle after the access. The bench compares every output against a behavioural model on every clock, in both variants, so each such fault is caught in the first cycle it reaches a port.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  // Kinds of register that an address can select
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_WAIT = 2'd2,
    SEL_ID   = 2'd3
  } bhc_sel_e;

  // Word offset of the wait register (byte offset 0x008)
  localparam int unsigned WAIT_WORD = 2;

  // Value loaded into every vector base register at reset
  localparam logic [31:0] VEC_RESET = 32'h1000_0000;

  // Identification byte for each of the four top words
  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = 8'h0D;
      2'd1:    b = 8'hF0;
      2'd2:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bhc_decode.sv
module bhc_decode
  import bhc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned WORD_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output bhc_sel_e          sel,
  output logic [IDX_W-1:0]  core_idx,
  output logic [1:0]        id_idx
);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign id_idx  = word[1:0];

  always_comb begin
    sel      = SEL_NONE;
    core_idx = '0;
    if (aligned) begin
      if (32'(word) < NUM_CORES) begin
        sel      = SEL_VEC;
        core_idx = word[IDX_W-1:0];
      end else if (32'(word) == WAIT_WORD) begin
        sel = SEL_WAIT;
      end else if (&word[WORD_W-1:2]) begin
        sel = SEL_ID;
      end
    end
  end

  // R8: a vector select never points past the cores that exist
  always_comb begin
    a_r8_vec_in_range : assert (sel != SEL_VEC || 32'(core_idx) < NUM_CORES);
  end

endmodule

// File: rtl/bhc_vec_slot.sv
module bhc_vec_slot #(
  parameter int unsigned DATA_W    = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wdata;
  end

  // R5: the base only moves after a write to it
  a_r5_vec_stable : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(q));

endmodule

// File: rtl/bhc_wait_ctrl.sv
module bhc_wait_ctrl #(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    wait_q,
  output logic [NUM_CORES-1:0] core_hold,
  output logic [NUM_CORES-1:0] core_release
);

  logic [NUM_CORES-1:0] falling;

  // Bits that go from 1 to 0 with this write
  assign falling = wait_q[NUM_CORES-1:0] & ~wdata[NUM_CORES-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q       <= RST_VAL;
      core_hold    <= RST_VAL[NUM_CORES-1:0];
      core_release <= '0;
    end else if (we) begin
      wait_q       <= wdata;
      core_release <= falling;
      core_hold    <= core_hold & ~falling;
    end else begin
      core_release <= '0;
    end
  end

  // R4: no hold bit is ever reasserted
  a_r4_hold_never_rises : assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold & ~$past(core_hold)) == '0);

  // R4: a hold only drops together with its release pulse
  a_r4_hold_drops_on_release : assert property (@(posedge clk) disable iff (!rst_n)
    ((~core_hold & $past(core_hold)) & ~core_release) == '0);

  // R3: a pulse lasts one cycle
  a_r3_release_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    (core_release & $past(core_release)) == '0);

  // R3: a pulse follows a write
  a_r3_release_after_write : assert property (@(posedge clk) disable iff (!rst_n)
    (core_release != '0) |-> $past(we));

endmodule

// File: rtl/boot_hold_ctrl.sv
module boot_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_err,
  output logic [NUM_CORES-1:0]        core_hold,
  output logic [NUM_CORES-1:0]        core_release,
  output logic [NUM_CORES*DATA_W-1:0] core_vec_base
);

  localparam int unsigned IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam logic [DATA_W-1:0] WAIT_RST = (NUM_CORES > 1) ? DATA_W'(2) : '0;

  bhc_sel_e          sel;
  logic [IDX_W-1:0]  core_idx;
  logic [1:0]        id_idx;
  logic [DATA_W-1:0] vec_q [NUM_CORES];
  logic [DATA_W-1:0] wait_q;
  logic [DATA_W-1:0] rd_val;
  logic              wait_we;

  bhc_decode #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .addr     (bus_addr),
    .sel      (sel),
    .core_idx (core_idx),
    .id_idx   (id_idx)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic vec_we;
    assign vec_we = bus_wr && (sel == SEL_VEC) && (core_idx == IDX_W'(c));

    bhc_vec_slot #(
      .DATA_W  (DATA_W),
      .RST_VAL (DATA_W'(VEC_RESET))
    ) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (vec_we),
      .wdata (bus_wdata),
      .q     (vec_q[c])
    );

    assign core_vec_base[c*DATA_W +: DATA_W] = vec_q[c];
  end

  assign wait_we = bus_wr && (sel == SEL_WAIT);

  bhc_wait_ctrl #(
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W),
    .RST_VAL   (WAIT_RST)
  ) u_wait (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (wait_we),
    .wdata        (bus_wdata),
    .wait_q       (wait_q),
    .core_hold    (core_hold),
    .core_release (core_release)
  );

  // Read selection
  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_VEC: begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (core_idx == IDX_W'(c)) rd_val = vec_q[c];
        end
      end
      SEL_WAIT: rd_val = wait_q;
      SEL_ID:   rd_val = DATA_W'(id_byte(id_idx));
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      bus_err   <= (bus_rd || bus_wr) && (sel == SEL_NONE);
    end
  end

  // R7: an errored access returns zero data
  a_r7_err_zero_data : assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R9: no read, no data
  a_r9_idle_rdata_zero : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == '0));

  // R7: an error needs an access in the cycle before
  a_r7_err_needs_access : assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(bus_rd) || $past(bus_wr)));

endmodule

// File: tb/boot_hold_ctrl_test.sv
`timescale 1ns/1ps
module boot_hold_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;

  logic [31:0] d_rdata, s_rdata;
  logic        d_err, s_err;
  logic [1:0]  d_hold, d_rel;
  logic [0:0]  s_hold, s_rel;
  logic [63:0] d_vec;
  logic [31:0] s_vec;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  boot_hold_ctrl #(.NUM_CORES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(d_rdata), .bus_err(d_err),
    .core_hold(d_hold), .core_release(d_rel), .core_vec_base(d_vec));

  boot_hold_ctrl #(.NUM_CORES(1)) uut_sc (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(s_rdata), .bus_err(s_err),
    .core_hold(s_hold), .core_release(s_rel), .core_vec_base(s_vec));

  // Behavioural model, index 0 = dual-core, 1 = single-core
  logic [31:0] m_wait [2];
  logic [1:0]  m_hold [2];
  logic [1:0]  m_rel  [2];
  logic [31:0] m_vec  [2][2];
  logic [31:0] m_rd   [2];
  logic        m_err  [2];

  // returns -1 miss, 0/1 vector, 2 wait, 3 id
  function automatic int kind_of(int nc, logic [11:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a == 12'h000) return 0;
    if (a == 12'h004) return (nc == 2) ? 1 : -1;
    if (a == 12'h008) return 2;
    if (a >= 12'hFF0) return 3;
    return -1;
  endfunction

  function automatic logic [31:0] id_val(logic [11:0] a);
    case (a)
      12'hFF0: return 32'h0D;
      12'hFF4: return 32'hF0;
      12'hFF8: return 32'h05;
      default: return 32'hB1;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int nc;
      int kd;
      logic [1:0] fall;
      logic [31:0] v;
      nc = (k == 0) ? 2 : 1;
      if (!rst_n) begin
        m_wait[k]   <= (nc == 2) ? 32'd2 : 32'd0;
        m_hold[k]   <= (nc == 2) ? 2'b10 : 2'b00;
        m_rel[k]    <= 2'b00;
        m_vec[k][0] <= 32'h1000_0000;
        m_vec[k][1] <= 32'h1000_0000;
        m_rd[k]     <= '0;
        m_err[k]    <= 1'b0;
      end else begin
        kd = kind_of(nc, addr);
        case (kd)
          0, 1:    v = m_vec[k][kd];
          2:       v = m_wait[k];
          3:       v = id_val(addr);
          default: v = '0;
        endcase
        m_rd[k]  <= rd ? v : '0;
        m_err[k] <= (rd || wr) && (kd < 0);
        m_rel[k] <= 2'b00;
        if (wr && (kd == 0 || kd == 1)) m_vec[k][kd] <= wdata;
        if (wr && kd == 2) begin
          fall = m_wait[k][1:0] & ~wdata[1:0];
          if (nc == 1) fall[1] = 1'b0;
          m_wait[k] <= wdata;
          m_rel[k]  <= fall;
          m_hold[k] <= m_hold[k] & ~fall;
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  // Per-clock comparison of every output
  always @(negedge clk) begin
    if (cyc > 1) begin
      chk("dual rdata (R9)", 64'(d_rdata), 64'(m_rd[0]));
      chk("dual err (R7)", 64'(d_err), 64'(m_err[0]));
      chk("dual hold (R4)", 64'(d_hold), 64'(m_hold[0]));
      chk("dual release (R3)", 64'(d_rel), 64'(m_rel[0]));
      chk("dual vec (R5)", d_vec, {m_vec[0][1], m_vec[0][0]});
      chk("single rdata (R8)", 64'(s_rdata), 64'(m_rd[1]));
      chk("single err (R8)", 64'(s_err), 64'(m_err[1]));
      chk("single hold", 64'(s_hold), 64'(m_hold[1][0]));
      chk("single release", 64'(s_rel), 64'(m_rel[1][0]));
      chk("single vec", 64'(s_vec), 64'(m_vec[1][0]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic op(bit w, bit r, logic [11:0] a, logic [31:0] d);
    wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wr_op(logic [11:0] a, logic [31:0] d); op(1'b1, 1'b0, a, d); endtask
  task automatic rd_op(logic [11:0] a); op(1'b0, 1'b1, a, '0); endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: directed reset values
    cur_req = "R1";
    chk("R1 dual hold", 64'(d_hold), 64'd2);
    chk("R1 single hold", 64'(s_hold), 64'd0);
    chk("R1 dual vec", d_vec, 64'h1000_0000_1000_0000);
    chk("R1 release", 64'(d_rel), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_op(12'h008);
    chk("R1 dual wait read", 64'(d_rdata), 64'd2);
    chk("R1 single wait read", 64'(s_rdata), 64'd0);
    rd_op(12'h000); rd_op(12'h004);

    cur_req = "R5";
    wr_op(12'h000, 32'h0000_4000);
    chk("R5 vec0 presented", d_vec[31:0], 64'h4000);
    wr_op(12'h004, 32'h2000_0100);
    chk("R5 vec1 presented", d_vec[63:32], 64'h2000_0100);
    rd_op(12'h000); rd_op(12'h004);

    cur_req = "R3";
    wr_op(12'h008, 32'h0);
    chk("R3 core1 release pulse", 64'(d_rel), 64'b10);
    chk("R4 core1 hold dropped", 64'(d_hold), 64'b00);
    @(negedge clk);
    chk("R3 pulse ended", 64'(d_rel), 64'b00);

    cur_req = "R4";
    wr_op(12'h008, 32'h3);
    chk("R4 no re-hold", 64'(d_hold), 64'b00);
    chk("R4 single no re-hold", 64'(s_hold), 64'b0);
    cur_req = "R2";
    rd_op(12'h008);
    chk("R2 wait stores 3", 64'(d_rdata), 64'd3);
    cur_req = "R3";
    wr_op(12'h008, 32'hFFFF_FFF0);
    chk("R3 both release", 64'(d_rel), 64'b11);
    chk("R3 single release", 64'(s_rel), 64'b1);
    cur_req = "R2";
    rd_op(12'h008);
    chk("R2 full value", 64'(d_rdata), 64'hFFFF_FFF0);
    wr_op(12'h008, 32'h8000_0002);
    chk("R3 no release on 0->1", 64'(d_rel), 64'b00);
    rd_op(12'h008);

    cur_req = "R6";
    rd_op(12'hFF0); rd_op(12'hFF4); rd_op(12'hFF8); rd_op(12'hFFC);
    chk("R6 last id", 64'(d_rdata), 64'hB1);
    wr_op(12'hFF4, 32'h1234_5678);
    chk("R6 no error", 64'(d_err), 64'd0);
    rd_op(12'hFF4);
    chk("R6 unchanged", 64'(d_rdata), 64'hF0);

    cur_req = "R7";
    rd_op(12'h00C);
    chk("R7 err", 64'(d_err), 64'd1);
    @(negedge clk);
    chk("R7 err one cycle", 64'(d_err), 64'd0);
    rd_op(12'h800); rd_op(12'h001); rd_op(12'hFF2);
    wr_op(12'h003, 32'h0);
    wr_op(12'h00C, 32'hDEAD_BEEF);
    rd_op(12'h008);

    cur_req = "R8";
    wr_op(12'h004, 32'h5555_0000);
    chk("R8 single err", 64'(s_err), 64'd1);
    chk("R8 dual ok", 64'(d_err), 64'd0);
    rd_op(12'h004);
    chk("R8 single zero", 64'(s_rdata), 64'd0);

    cur_req = "R9";
    op(1'b1, 1'b1, 12'h000, 32'hAAAA_0001);
    chk("R9 read old value", 64'(d_rdata), 64'h4000);
    rd_op(12'h000);
    rd_op(12'h008);
    @(negedge clk);
    chk("R9 idle zero", 64'(d_rdata), 64'd0);

    cur_req = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 re-reset hold", 64'(d_hold), 64'd2);
    rst_n = 1'b1;
    rd_op(12'h004);
    chk("R1 re-reset vec1", 64'(d_rdata), 64'h1000_0000);
    repeat (3) @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule